// File: doc/BRIEF.md
# Four-Bit ALU Slice with Group Carry Lookahead Outputs

This block is one slice of a wider arithmetic unit. It accepts two operands, a carry input and a three-bit function code, and produces a result word together with active-low group carry-generate and group carry-propagate flags. The generate and propagate flags feed an external carry-lookahead unit, so several slices can form a longer word without rippling carries between them. The slice has no carry-out or overflow pin. Those values are expected to come from the lookahead unit.

The eight function codes cover four groups:
- three arithmetic operations: add, and subtract in either direction;
- three bitwise operations on the raw operands;
- a forced all-zeros result;
- a forced all-ones result.

Operands are treated as active-high. For a true difference, the caller drives the carry input high. All outputs are registered, so each result appears one clock after its inputs are sampled. A synchronous active-high reset puts the outputs into the state that the clear code produces.

Code bits are written func_sel[2:0], where bit 0 is the lowest select line.

Top module: `lookahead_alu_slice`

## Requirements
- R1: While rst is high at a rising clock edge, that edge sets f_out to 0, grp_gen_n to 0 and grp_prop_n to 0.
- R2: Every output takes the value computed from the inputs present at a rising edge, and holds that value until the next rising edge.
- R3: Code 3'b000 gives f_out = 0, with grp_gen_n and grp_prop_n both driven low.
- R4: Code 3'b001 gives f_out = (b_in + ~a_in + carry_in) mod 2^WIDTH.
- R5: Code 3'b010 gives f_out = (a_in + ~b_in + carry_in) mod 2^WIDTH.
- R6: Code 3'b011 gives f_out = (a_in + b_in + carry_in) mod 2^WIDTH.
- R7: The bitwise and forced codes give these results: code 3'b100 gives a_in XOR b_in, 3'b101 gives a_in OR b_in, 3'b110 gives a_in AND b_in, and 3'b111 gives all ones.
- R8: carry_in has no effect on any output for codes 3'b000, 3'b100, 3'b101, 3'b110 and 3'b111.
- R9: For every code except 3'b000, define the effective operands x and y:
  - x is ~a_in for code 3'b001 and a_in otherwise;
  - y is ~b_in for code 3'b010 and b_in otherwise.
  
  grp_prop_n is low exactly when (x | y) is all ones.
- R10: For every code except 3'b000, grp_gen_n is low exactly when the group generates a carry. Each bit generates g_i = x_i & y_i and propagates p_i = x_i | y_i. The group generate is built from bit 0 upward as G = g_i | (p_i & G), starting from G = 0.
- R11: Code 3'b001 with a_in equal to b_in gives all ones when carry_in is 0, and gives 0 when carry_in is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH (4) | First operand |
| b_in | input | WIDTH (4) | Second operand |
| carry_in | input | 1 | Carry into the least significant bit |
| func_sel | input | 3 | Function code |
| f_out | output | WIDTH (4) | Registered result |
| grp_gen_n | output | 1 | Registered group carry generate, active low |
| grp_prop_n | output | 1 | Registered group carry propagate, active low |

## Verification
Each result, and both lookahead flags, are due at the first rising edge after the inputs are applied, and then stay fixed for one full cycle. The bench changes its inputs on falling edges and reads the outputs at the next falling edge, which is half a period after the capturing edge. Straight after applying a new vector, the bench also confirms that the outputs still show the previous vector's result; this is how the one-cycle delay is checked. The bench sweeps all codes, operand pairs and carry values, and compares each carry-in-1 result with its carry-in-0 twin in the modes that ignore the carry.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  // Function codes; bit 0 is the lowest select line.
  typedef enum logic [2:0] {
    FN_CLEAR     = 3'b000,
    FN_B_MINUS_A = 3'b001,
    FN_A_MINUS_B = 3'b010,
    FN_ADD       = 3'b011,
    FN_XOR       = 3'b100,
    FN_OR        = 3'b101,
    FN_AND       = 3'b110,
    FN_PRESET    = 3'b111
  } alu_fn_e;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  alu_fn_e          fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y,
  output logic             force_low
);

  // The subtract codes invert one operand.
  // Every other code passes both operands through unchanged.
  always_comb begin
    x         = (fn == FN_B_MINUS_A) ? ~a : a;
    y         = (fn == FN_A_MINUS_B) ? ~b : b;
    force_low = (fn == FN_CLEAR);
  end

endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             grp_gen,
  output logic             grp_prop
);

  logic [WIDTH-1:0] bit_g;
  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] carry;
  logic [WIDTH:0]   gen_acc;

  assign carry[0]   = cin;
  assign gen_acc[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_g[i]       = x[i] & y[i];
    assign bit_p[i]       = x[i] | y[i];
    assign sum[i]         = x[i] ^ y[i] ^ carry[i];
    assign gen_acc[i+1]   = bit_g[i] | (bit_p[i] & gen_acc[i]);
    if (i < WIDTH - 1) begin : g_carry
      assign carry[i+1] = bit_g[i] | (bit_p[i] & carry[i]);
    end
  end

  assign grp_gen  = gen_acc[WIDTH];
  assign grp_prop = &bit_p;

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  alu_fn_e          fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] f
);

  always_comb begin
    unique case (fn)
      FN_CLEAR:                          f = '0;
      FN_B_MINUS_A, FN_A_MINUS_B, FN_ADD: f = sum;
      FN_XOR:                            f = a ^ b;
      FN_OR:                             f = a | b;
      FN_AND:                            f = a & b;
      FN_PRESET:                         f = '1;
      default:                           f = '0;
    endcase
  end

endmodule

// File: rtl/lookahead_alu_slice.sv
module lookahead_alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic [2:0]       func_sel,
  output logic [WIDTH-1:0] f_out,
  output logic             grp_gen_n,
  output logic             grp_prop_n
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  alu_fn_e          fn;
  logic [WIDTH-1:0] op_x;
  logic [WIDTH-1:0] op_y;
  logic             force_low;
  logic [WIDTH-1:0] sum;
  logic             grp_gen;
  logic             grp_prop;
  logic [WIDTH-1:0] f_d;

  assign fn = alu_fn_e'(func_sel);

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .fn        (fn),
    .a         (a_in),
    .b         (b_in),
    .x         (op_x),
    .y         (op_y),
    .force_low (force_low)
  );

  alu_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .x        (op_x),
    .y        (op_y),
    .cin      (carry_in),
    .sum      (sum),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  alu_result_sel #(.WIDTH(WIDTH)) u_sel (
    .fn  (fn),
    .a   (a_in),
    .b   (b_in),
    .sum (sum),
    .f   (f_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_out      <= '0;
      grp_gen_n  <= 1'b0;
      grp_prop_n <= 1'b0;
    end else begin
      f_out      <= f_d;
      grp_gen_n  <= force_low ? 1'b0 : ~grp_gen;
      grp_prop_n <= force_low ? 1'b0 : ~grp_prop;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (f_out == ALL_ZERO && !grp_gen_n && !grp_prop_n)); // R1

  AST_CLEAR_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
    func_sel == 3'b000 |=> (f_out == ALL_ZERO && !grp_gen_n && !grp_prop_n)); // R3

  AST_ADD_ZERO_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    (func_sel == 3'b011 && a_in == ALL_ZERO && b_in == ALL_ZERO)
      |=> (f_out == {{(WIDTH-1){1'b0}}, $past(carry_in)} && grp_gen_n)); // R6

  AST_XOR_SAME_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (func_sel == 3'b100 && a_in == b_in) |=> f_out == ALL_ZERO); // R7

  AST_PRESET_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    func_sel == 3'b111 |=> f_out == ALL_ONES); // R7

  AST_ADD_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (func_sel == 3'b011 && (a_in | b_in) == ALL_ONES) |=> !grp_prop_n); // R9

  AST_SUB_EQUAL_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    (func_sel == 3'b001 && a_in == b_in)
      |=> f_out == ($past(carry_in) ? ALL_ZERO : ALL_ONES)); // R11

endmodule

// File: tb/sim_lookahead_alu_slice.sv
module sim_lookahead_alu_slice;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int MASK       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         carry_in = 1'b0;
  logic [2:0]   func_sel = 3'b000;
  logic [W-1:0] f_out;
  logic         grp_gen_n;
  logic         grp_prop_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lookahead_alu_slice #(.WIDTH(W)) u0 (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .b_in       (b_in),
    .carry_in   (carry_in),
    .func_sel   (func_sel),
    .f_out      (f_out),
    .grp_gen_n  (grp_gen_n),
    .grp_prop_n (grp_prop_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (fn=%0d a=%0d b=%0d c=%0d)",
               tag, act, exp, func_sel, a_in, b_in, carry_in);
    end
  endtask

  function automatic string fn_tag(input int fn);
    case (fn)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int prev_f, prev_g, prev_p;
    int c0_f, c0_g, c0_p;
    prev_f = 0; prev_g = 0; prev_p = 0;
    c0_f = 0; c0_g = 0; c0_p = 0;

    // Reset checks (R1).
    @(negedge clk);
    @(negedge clk);
    chk("R1 f_out", int'(f_out), 0);
    chk("R1 grp_gen_n", int'(grp_gen_n), 0);
    chk("R1 grp_prop_n", int'(grp_prop_n), 0);
    rst = 1'b0;

    for (int fn = 0; fn < 8; fn++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int c = 0; c < 2; c++) begin
            int x, y, s, ef, eg, ep, gg;
            func_sel = 3'(fn);
            a_in     = W'(a);
            b_in     = W'(b);
            carry_in = 1'(c);
            #1;
            // R2: the outputs must not move before the edge.
            chk("R2 hold f_out", int'(f_out), prev_f);
            chk("R2 hold grp_gen_n", int'(grp_gen_n), prev_g);

            x = (fn == 1) ? (~a & MASK) : a;
            y = (fn == 2) ? (~b & MASK) : b;
            s = (x + y + c) & MASK;
            case (fn)
              0: ef = 0;
              1, 2, 3: ef = s;
              4: ef = a ^ b;
              5: ef = a | b;
              6: ef = a & b;
              default: ef = MASK;
            endcase
            gg = 0;
            for (int i = 0; i < W; i++) begin
              int gi, pi;
              gi = ((x >> i) & (y >> i)) & 1;
              pi = ((x >> i) | (y >> i)) & 1;
              gg = gi | (pi & gg);
            end
            ep = (fn == 0) ? 0 : (((x | y) == MASK) ? 0 : 1);
            eg = (fn == 0) ? 0 : (gg ? 0 : 1);

            @(posedge clk);
            @(negedge clk);
            chk(fn_tag(fn), int'(f_out), ef);
            chk("R10 grp_gen_n", int'(grp_gen_n), eg);
            chk("R9 grp_prop_n", int'(grp_prop_n), ep);
            if (fn == 1 && a == b)
              chk("R11 equal-operand difference", int'(f_out), c ? 0 : MASK);
            if (fn == 0 || fn >= 4) begin
              if (c == 0) begin
                c0_f = int'(f_out); c0_g = int'(grp_gen_n); c0_p = int'(grp_prop_n);
              end else begin
                chk("R8 carry ignored f_out", int'(f_out), c0_f);
                chk("R8 carry ignored grp_gen_n", int'(grp_gen_n), c0_g);
                chk("R8 carry ignored grp_prop_n", int'(grp_prop_n), c0_p);
              end
            end
            prev_f = ef;
            prev_g = eg;
            prev_p = ep;
          end
        end
      end
    end

    // Reset in mid-run returns the outputs to the clear state (R1).
    func_sel = 3'b111;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid-run f_out", int'(f_out), 0);
    chk("R1 mid-run grp_prop_n", int'(grp_prop_n), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule